// File: doc/BRIEF.md
# Segment Selector Translation Unit

The unit turns a logical address, given as a segment register number plus a 32-bit offset, into a 32-bit linear address. It holds six segment registers. Each one keeps a 16-bit selector that software can see and a hidden copy of the segment's descriptor, so a translation never has to touch memory. A translation adds the cached segment base to the offset. Before that it compares the offset with the segment limit and checks the write and privilege attributes. A faulting translation reports a fault code and produces no address.

A selector load names a register and a selector. Selector bit 2 picks the local descriptor table (1) or the global one (0), and bits 15:3 index an 8-byte descriptor in that table. The unit reads the two 32-bit words of the descriptor over a simple memory read port, one word at a time, and installs them in the register. While the fetch is in flight, that register is busy. Translations through it stall, and the other five registers keep translating from their cached copies.

Descriptor layout: word 0 holds the base. In word 1, bits 19:0 hold the limit, bit 20 is writable, bit 21 is supervisor-only, and bit 22 is granularity.

Top module: `seg_xlate`

## Requirements
- R1: After reset every register has base 0, limit 0xFFFFFFFF, writable, user-accessible. Every translation then returns the offset unchanged with no fault, and load_ready_o is 1.
- R2: A load of selector S reads word address T + 8*S[15:3] and then T + 8*S[15:3] + 4. T is ldt_base_i when S[2] is 1, otherwise gdt_base_i. Word 0 becomes the base and word 1 the attributes.
- R3: A non-faulting translation returns base + offset modulo 2^32.
- R4: The effective limit is word1[19:0] when bit 22 is 0, and word1[19:0]*4096 + 4095 when bit 22 is 1. An offset above the effective limit gives fault code 1.
- R5: If word1 bit 21 is set and the access is user-level (xl_user_i = 1, or the stored selector's bits 1:0 are non-zero), the translation gives fault code 2.
- R6: A write (xl_write_i = 1) to a segment whose word1 bit 20 is 0 gives fault code 3. When several faults apply, code 1 wins over code 2, and code 2 wins over code 3.
- R7: A faulting translation shows xl_fault_o = 1, a non-zero xl_code_o and xl_lin_o = 0. A clean one shows xl_fault_o = 0 and xl_code_o = 0.
- R8: A load is accepted only while load_ready_o is 1. load_ready_o stays 0 from acceptance until the second word arrives. During that time xl_ready_o is 0 for the register being loaded, while other registers translate from their old contents.
- R9: A translation accepted on a clock edge (xl_valid_i and xl_ready_o both 1) shows its result with a one-cycle xl_done_o pulse after that edge. The first translation through a register accepted after its load completes uses the new descriptor.
- R10: mem_req_o stays high with a stable mem_addr_o until mem_rvalid_i is returned for that word.
- R11: A load naming register 6 or 7 is dropped with no memory read. A translation through register 6 or 7 gives fault code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gdt_base_i | input | 32 | Global table base address |
| ldt_base_i | input | 32 | Local table base address |
| load_valid_i | input | 1 | Selector load request |
| load_seg_i | input | 3 | Register to load |
| load_sel_i | input | 16 | Selector value |
| load_ready_o | output | 1 | Fetch engine idle, load can be accepted |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 32 | Descriptor word address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| xl_valid_i | input | 1 | Translation request |
| xl_seg_i | input | 3 | Register used for translation |
| xl_off_i | input | 32 | Offset |
| xl_write_i | input | 1 | Access is a write |
| xl_user_i | input | 1 | Access is at user level |
| xl_ready_o | output | 1 | Translation can be accepted this cycle |
| xl_done_o | output | 1 | Result valid pulse |
| xl_fault_o | output | 1 | Translation faulted |
| xl_code_o | output | 2 | Fault code: 0 none, 1 limit, 2 privilege, 3 read-only write |
| xl_lin_o | output | 32 | Linear address |

## Verification
A selector fetch and a translation can be active in the same cycle. They can even target the same register at the edge where the second descriptor word lands. The bench starts a load and, before it finishes, issues translations to other registers and to the register being loaded. The memory model returns each word after a random delay. Other-register results are judged against the old cached descriptor. For the register being loaded, the bench checks that acceptance is held off and that the first accepted result reflects the new descriptor.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NUM_SEG = 6;
  localparam int SEG_W   = 3;
  localparam int AW      = 32;
  localparam int SEL_W   = 16;
  localparam int LIM_W   = 20;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [AW-1:0]    base;
    logic [LIM_W-1:0] limit;
    logic             wr;
    logic             sup;
    logic             gran;
  } seg_ent_t;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_PRIV  = 2'd2,
    FLT_RO    = 2'd3
  } flt_e;

  function automatic seg_ent_t flat_ent();
    seg_ent_t e;
    e.sel   = '0;
    e.base  = '0;
    e.limit = '1;
    e.wr    = 1'b1;
    e.sup   = 1'b0;
    e.gran  = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/seg_fetch.sv
module seg_fetch
  import seg_pkg::*;
#(
  parameter int N_SEG = NUM_SEG,
  parameter int S_W   = SEG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    gdt_base_i,
  input  logic [AW-1:0]    ldt_base_i,
  input  logic             load_valid_i,
  input  logic [S_W-1:0]   load_seg_i,
  input  logic [SEL_W-1:0] load_sel_i,
  output logic             load_ready_o,
  output logic             busy_o,
  output logic [S_W-1:0]   busy_seg_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             wr_en_o,
  output logic [S_W-1:0]   wr_seg_o,
  output seg_ent_t         wr_ent_o
);
  localparam int IDX_W = SEL_W - 3;

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fst_e;

  fst_e             st_q;
  logic [AW-1:0]    addr_q;
  logic [AW-1:0]    base_q;
  logic [SEL_W-1:0] sel_q;
  logic [S_W-1:0]   seg_q;
  logic             accept;
  logic [AW-1:0]    tbl_base;
  logic [AW-1:0]    idx_off;

  assign accept   = load_valid_i && (st_q == F_IDLE) && (int'(load_seg_i) < N_SEG);
  assign tbl_base = load_sel_i[2] ? ldt_base_i : gdt_base_i;
  assign idx_off  = {{(AW-IDX_W-3){1'b0}}, load_sel_i[SEL_W-1:3], 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      addr_q <= '0;
      base_q <= '0;
      sel_q  <= '0;
      seg_q  <= '0;
    end else begin
      unique case (st_q)
        F_IDLE: if (accept) begin
          st_q   <= F_LO;
          addr_q <= tbl_base + idx_off;
          sel_q  <= load_sel_i;
          seg_q  <= load_seg_i;
        end
        F_LO: if (mem_rvalid_i) begin
          st_q   <= F_HI;
          base_q <= mem_rdata_i;
          addr_q <= addr_q + AW'(4);
        end
        F_HI: if (mem_rvalid_i) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign load_ready_o = (st_q == F_IDLE);
  assign busy_o       = (st_q != F_IDLE);
  assign busy_seg_o   = seg_q;
  assign mem_req_o    = busy_o;
  assign mem_addr_o   = addr_q;

  assign wr_en_o        = (st_q == F_HI) && mem_rvalid_i;
  assign wr_seg_o       = seg_q;
  assign wr_ent_o.sel   = sel_q;
  assign wr_ent_o.base  = base_q;
  assign wr_ent_o.limit = mem_rdata_i[LIM_W-1:0];
  assign wr_ent_o.wr    = mem_rdata_i[20];
  assign wr_ent_o.sup   = mem_rdata_i[21];
  assign wr_ent_o.gran  = mem_rdata_i[22];
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int N_SEG = NUM_SEG,
  parameter int S_W   = SEG_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [S_W-1:0] wr_seg_i,
  input  seg_ent_t       wr_ent_i,
  input  logic [S_W-1:0] rd_seg_i,
  output logic           rd_ok_o,
  output seg_ent_t       rd_ent_o
);
  seg_ent_t ent_q [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 ent_q[g] <= flat_ent();
      else if (wr_en_i && (int'(wr_seg_i) == g))   ent_q[g] <= wr_ent_i;
    end
  end

  always_comb begin
    rd_ok_o  = 1'b0;
    rd_ent_o = flat_ent();
    for (int i = 0; i < N_SEG; i++) begin
      if (int'(rd_seg_i) == i) begin
        rd_ok_o  = 1'b1;
        rd_ent_o = ent_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
(
  input  logic          ok_i,
  input  seg_ent_t      ent_i,
  input  logic [AW-1:0] off_i,
  input  logic          write_i,
  input  logic          user_i,
  output logic [1:0]    code_o,
  output logic [AW-1:0] lin_o
);
  logic [AW-1:0] eff_lim;
  logic          user_eff;

  assign eff_lim  = ent_i.gran ? {ent_i.limit, 12'hFFF}
                               : {{(AW-LIM_W){1'b0}}, ent_i.limit};
  assign user_eff = user_i || (ent_i.sel[1:0] != 2'b00);

  always_comb begin
    if (!ok_i || (off_i > eff_lim)) code_o = FLT_LIMIT;
    else if (ent_i.sup && user_eff) code_o = FLT_PRIV;
    else if (write_i && !ent_i.wr)  code_o = FLT_RO;
    else                            code_o = FLT_NONE;
  end

  assign lin_o = (code_o == FLT_NONE) ? ent_i.base + off_i : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int N_SEG = NUM_SEG,
  parameter int S_W   = SEG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    gdt_base_i,
  input  logic [AW-1:0]    ldt_base_i,
  input  logic             load_valid_i,
  input  logic [S_W-1:0]   load_seg_i,
  input  logic [SEL_W-1:0] load_sel_i,
  output logic             load_ready_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  input  logic             xl_valid_i,
  input  logic [S_W-1:0]   xl_seg_i,
  input  logic [AW-1:0]    xl_off_i,
  input  logic             xl_write_i,
  input  logic             xl_user_i,
  output logic             xl_ready_o,
  output logic             xl_done_o,
  output logic             xl_fault_o,
  output logic [1:0]       xl_code_o,
  output logic [AW-1:0]    xl_lin_o
);
  logic           busy;
  logic [S_W-1:0] busy_seg;
  logic           wr_en;
  logic [S_W-1:0] wr_seg;
  seg_ent_t       wr_ent;
  logic           rd_ok;
  seg_ent_t       rd_ent;
  logic [1:0]     code;
  logic [AW-1:0]  lin;
  logic           xl_acc;

  seg_fetch #(.N_SEG(N_SEG), .S_W(S_W)) u_fetch (
    .clk_i, .rst_ni, .gdt_base_i, .ldt_base_i,
    .load_valid_i, .load_seg_i, .load_sel_i, .load_ready_o,
    .busy_o(busy), .busy_seg_o(busy_seg),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .wr_en_o(wr_en), .wr_seg_o(wr_seg), .wr_ent_o(wr_ent)
  );

  seg_regfile #(.N_SEG(N_SEG), .S_W(S_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_seg_i(wr_seg), .wr_ent_i(wr_ent),
    .rd_seg_i(xl_seg_i), .rd_ok_o(rd_ok), .rd_ent_o(rd_ent)
  );

  seg_check u_check (
    .ok_i(rd_ok), .ent_i(rd_ent), .off_i(xl_off_i),
    .write_i(xl_write_i), .user_i(xl_user_i),
    .code_o(code), .lin_o(lin)
  );

  // stall only the register whose descriptor is in flight
  assign xl_ready_o = !(busy && (xl_seg_i == busy_seg));
  assign xl_acc     = xl_valid_i && xl_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xl_done_o  <= 1'b0;
      xl_fault_o <= 1'b0;
      xl_code_o  <= '0;
      xl_lin_o   <= '0;
    end else begin
      xl_done_o <= xl_acc;
      if (xl_acc) begin
        xl_fault_o <= (code != FLT_NONE);
        xl_code_o  <= code;
        xl_lin_o   <= lin;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_pkg::*;
#(
  parameter int S_W = SEG_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           xl_valid_i,
  input logic [S_W-1:0] xl_seg_i,
  input logic           xl_ready_o,
  input logic           xl_done_o,
  input logic           xl_fault_o,
  input logic [1:0]     xl_code_o,
  input logic [AW-1:0]  xl_lin_o,
  input logic           load_ready_o,
  input logic           mem_req_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic           mem_rvalid_i,
  input logic           busy,
  input logic [S_W-1:0] busy_seg
);
  a_r8_stall_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && xl_valid_i && (xl_seg_i == busy_seg)) |-> !xl_ready_o);

  a_r8_no_load_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !load_ready_o);

  a_r9_done_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_done_o |-> $past(xl_valid_i && xl_ready_o));

  a_r7_fault_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_done_o && xl_fault_o) |-> (xl_lin_o == '0));

  a_r7_code_agrees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_done_o |-> (xl_fault_o == (xl_code_o != 2'd0)));

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

bind seg_xlate seg_xlate_chk #(.S_W(S_W)) u_chk (
  .clk_i, .rst_ni, .xl_valid_i, .xl_seg_i, .xl_ready_o, .xl_done_o,
  .xl_fault_o, .xl_code_o, .xl_lin_o, .load_ready_o, .mem_req_o,
  .mem_addr_o, .mem_rvalid_i, .busy, .busy_seg
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] gdt_base_i = 32'h0001_0000;
  logic [31:0] ldt_base_i = 32'h0002_0000;
  logic        load_valid_i = 1'b0;
  logic [2:0]  load_seg_i = '0;
  logic [15:0] load_sel_i = '0;
  logic        load_ready_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        xl_valid_i = 1'b0;
  logic [2:0]  xl_seg_i = '0;
  logic [31:0] xl_off_i = '0;
  logic        xl_write_i = 1'b0;
  logic        xl_user_i = 1'b0;
  logic        xl_ready_o, xl_done_o, xl_fault_o;
  logic [1:0]  xl_code_o;
  logic [31:0] xl_lin_o;

  always #2.5 clk_i = ~clk_i;

  seg_xlate u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] g_lo [32], g_hi [32], l_lo [32], l_hi [32];
  logic [15:0] m_sel  [6];
  logic [31:0] m_base [6];
  logic [31:0] m_hi   [6];
  bit          pend = 0;
  int          pend_seg = 0;
  logic [31:0] alog [2];
  int          acnt = 0;
  int          lat = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (a >= 32'h0001_0000 && a < 32'h0001_0100)
      return a[2] ? g_hi[a[7:3]] : g_lo[a[7:3]];
    if (a >= 32'h0002_0000 && a < 32'h0002_0100)
      return a[2] ? l_hi[a[7:3]] : l_lo[a[7:3]];
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [31:0] tbl_addr(input logic [15:0] s);
    return (s[2] ? 32'h0002_0000 : 32'h0001_0000) + {16'd0, s[15:3], 3'b000};
  endfunction

  // returns code in [33:32], linear address in [31:0]
  function automatic logic [33:0] expect_xl(input int seg, input logic [31:0] off,
                                            input bit w, input bit u);
    logic [31:0] lim, hi;
    if (seg > 5) return {2'd1, 32'd0};
    hi  = m_hi[seg];
    lim = hi[22] ? {hi[19:0], 12'hFFF} : {12'd0, hi[19:0]};
    if (off > lim) return {2'd1, 32'd0};
    if (hi[21] && (u || m_sel[seg][1:0] != 2'b00)) return {2'd2, 32'd0};
    if (w && !hi[20]) return {2'd3, 32'd0};
    return {2'd0, m_base[seg] + off};
  endfunction

  // memory responder
  always @(negedge clk_i) begin
    if (mem_rvalid_i) begin
      mem_rvalid_i <= 1'b0;
      lat <= $urandom_range(0, 3);
    end else if (mem_req_o) begin
      if (lat == 0) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= mem_rd(mem_addr_o);
        if (acnt < 2) alog[acnt] = mem_addr_o;
        acnt++;
      end else lat <= lat - 1;
    end
  end

  task automatic load_start(input int seg, input logic [15:0] sel);
    @(negedge clk_i);
    while (!load_ready_o) @(negedge clk_i);
    chk(load_ready_o, "R8 load_ready before load", {31'd0, load_ready_o}, 32'd1);
    acnt = 0;
    load_valid_i = 1'b1; load_seg_i = 3'(seg); load_sel_i = sel;
    @(negedge clk_i);
    load_valid_i = 1'b0;
    if (seg < 6) begin
      chk(!load_ready_o, "R8 busy after load", {31'd0, load_ready_o}, 32'd0);
      m_sel[seg]  = sel;
      m_base[seg] = mem_rd(tbl_addr(sel));
      m_hi[seg]   = mem_rd(tbl_addr(sel) + 32'd4);
      pend = 1; pend_seg = seg;
    end
  endtask

  task automatic load_wait();
    logic [31:0] ta;
    if (!pend) return;
    while (!load_ready_o) @(negedge clk_i);
    ta = tbl_addr(m_sel[pend_seg]);
    chk(acnt == 2 && alog[0] == ta, "R2 first word address", alog[0], ta);
    chk(alog[1] == ta + 32'd4, "R2 second word address", alog[1], ta + 32'd4);
    pend = 0;
  endtask

  task automatic translate(input int seg, input logic [31:0] off, input bit w,
                           input bit u, input string req);
    logic [33:0] e;
    int stalls = 0;
    bit was_pend;
    was_pend = pend && (pend_seg == seg);
    xl_valid_i = 1'b1; xl_seg_i = 3'(seg); xl_off_i = off;
    xl_write_i = w; xl_user_i = u;
    #1;
    while (!xl_ready_o) begin
      stalls++;
      @(negedge clk_i); #1;
    end
    if (was_pend) begin
      chk(stalls > 0, "R8 stall on register being loaded", stalls, 32'd1);
      pend = 0;
    end else
      chk(stalls == 0, "R8 other register not stalled", stalls, 32'd0);
    e = expect_xl(seg, off, w, u);
    @(negedge clk_i);
    xl_valid_i = 1'b0;
    chk(xl_done_o, "R9 done pulse", {31'd0, xl_done_o}, 32'd1);
    chk(xl_code_o == e[33:32] && xl_fault_o == (e[33:32] != 2'd0),
        {req, " fault code"}, {30'd0, xl_code_o}, {30'd0, e[33:32]});
    chk(xl_lin_o == e[31:0], {req, " linear address"}, xl_lin_o, e[31:0]);
    @(negedge clk_i);
    chk(!xl_done_o, "R9 done single cycle", {31'd0, xl_done_o}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin
      g_lo[i] = $urandom; l_lo[i] = $urandom;
      g_hi[i] = {9'd0, 3'($urandom), 20'($urandom)} | 32'h0010_0000;
      l_hi[i] = {9'd0, 3'($urandom), 20'($urandom)};
    end
    // directed descriptors
    g_lo[1] = 32'h0000_1000; g_hi[1] = 32'h0010_00FF;             // rw, user, limit 0xFF
    g_lo[2] = 32'h0000_2000; g_hi[2] = 32'h0030_0FFF;             // supervisor
    g_lo[3] = 32'h0000_3000; g_hi[3] = 32'h0000_0FFF;             // read-only
    g_lo[4] = 32'hFFFF_F000; g_hi[4] = 32'h0050_0002;             // gran, wraps
    g_lo[5] = 32'h0000_5000; g_hi[5] = 32'h0020_0010;             // sup, ro, limit 0x10
    for (int s = 0; s < 6; s++) begin
      m_sel[s] = '0; m_base[s] = '0; m_hi[s] = 32'h005F_FFFF;
    end
    repeat (3) @(negedge clk_i);
    chk(load_ready_o && !mem_req_o && !xl_done_o, "R1 reset outputs",
        {29'd0, load_ready_o, mem_req_o, xl_done_o}, 32'd4);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int s = 0; s < 6; s++) translate(s, $urandom, 1'b1, 1'b1, "R1 flat");
    translate(0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R1 flat top");

    load_start(0, 16'h0008); load_wait();                 // gdt[1]
    translate(0, 32'h0000_0040, 1'b1, 1'b1, "R3 base add");
    translate(0, 32'h0000_00FF, 1'b0, 1'b0, "R4 limit edge");
    translate(0, 32'h0000_0100, 1'b0, 1'b0, "R4 limit over");
    load_start(1, 16'h0010); load_wait();                 // supervisor
    translate(1, 32'h10, 1'b0, 1'b1, "R5 user on supervisor");
    translate(1, 32'h10, 1'b1, 1'b0, "R5 kernel on supervisor");
    load_start(1, 16'h0013); load_wait();                 // rpl 3
    translate(1, 32'h10, 1'b0, 1'b0, "R5 selector rpl");
    load_start(2, 16'h0018); load_wait();
    translate(2, 32'h20, 1'b1, 1'b0, "R6 write read-only");
    translate(2, 32'h20, 1'b0, 1'b1, "R6 read read-only");
    load_start(3, 16'h0028); load_wait();                 // priority
    translate(3, 32'h11, 1'b1, 1'b1, "R6 priority limit");
    translate(3, 32'h05, 1'b1, 1'b1, "R6 priority priv");
    load_start(4, 16'h0020); load_wait();
    translate(4, 32'h0000_2FFF, 1'b0, 1'b0, "R4 gran edge");
    translate(4, 32'h0000_3000, 1'b0, 1'b0, "R4 gran over");
    translate(4, 32'h0000_1800, 1'b0, 1'b0, "R3 wrap");
    load_start(5, 16'hFFFC); load_wait();                 // ldt, far index
    translate(5, 32'h0, 1'b0, 1'b0, "R2 ldt far index");
    load_start(6, 16'h0008);
    repeat (4) begin
      @(negedge clk_i);
      chk(!mem_req_o && load_ready_o, "R11 dropped load", {31'd0, mem_req_o}, 32'd0);
    end
    translate(7, 32'h0, 1'b0, 1'b0, "R11 bad register");

    // concurrent: load in flight, translations to other and same register
    for (int k = 0; k < 40; k++) begin
      int s, o;
      s = $urandom_range(0, 5);
      load_start(s, 16'($urandom_range(0, 63)));
      o = (s + 1 + $urandom_range(0, 4)) % 6;
      if (!mem_rvalid_i) translate(o, $urandom_range(0, 300), 1'($urandom), 1'($urandom), "R8 side translate");
      translate(s, $urandom_range(0, 300), 1'($urandom), 1'($urandom), "R9 new descriptor");
      load_wait();
    end

    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        load_start($urandom_range(0, 5), 16'($urandom));
        load_wait();
      end else begin
        translate($urandom_range(0, 7),
                  ($urandom_range(0, 1) == 1) ? $urandom : 32'($urandom_range(0, 4200)),
                  1'($urandom), 1'($urandom), "R3 random");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule